// File: doc/BRIEF.md
# Spike Event Priority Serializer

The block gathers firing events from a group of neighbouring neurons and sends them, one at a time, over a single serial event lane. Each neuron raises its request line when it fires. A rising edge marks the neuron as pending. A fixed-priority arbiter then chooses one pending neuron whenever the lane is free. It sends that neuron's programmable identifier, not its input position, as a short self-timed frame.

There is no request/grant handshake toward the neurons and no event queue. A neuron that loses arbitration stays pending and is sent later, so simultaneous firing costs timing accuracy but loses no events. A startup control forces every payload to zero. This gives downstream receivers a known pattern to train on.

An identifier table holds the payload for each input. It is written through a simple write port, one entry per clock edge.

Top module: `spike_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ser_o` is held high (idle level).
- R2: If `req_i[i]` is first sampled high at clock edge k while the lane is idle, the start bit of its frame is driven from clock edge k+1.
- R3: A frame is eight bit periods long, and each bit period lasts `BIT_CYC` clock cycles. Bit 0 is the start bit (low). Bits 1 to 6 are the payload, most significant bit first. Bit 7 is the stop bit (high).
- R4: The payload is the identifier stored for the winning input. After reset, entry i holds i modulo 64. A write with `cfg_we_i` high stores `cfg_id_i` at entry `cfg_addr_i` and applies to frames launched after that edge.
- R5: When several inputs are pending, they are sent one frame each, with the lowest input index first.
- R6: A frame starts only after the previous stop bit has ended. If an input is pending at that point, its start bit directly follows the stop bit, with no idle cycle between them.
- R7: When `startup_i` is high at the edge that launches a frame, the payload is 000000 whatever the table holds.
- R8: A second rising edge on an input that is still pending merges with the first, so only one frame is sent.
- R9: A rising edge that arrives after the input's frame has launched produces another frame.
- R10: A request held high for many cycles produces a single frame; only rising edges count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Firing request per neuron; a rising edge is an event |
| cfg_we_i | input | 1 | Identifier table write enable |
| cfg_addr_i | input | IDX_W | Table entry to write |
| cfg_id_i | input | ID_W | Identifier value to write |
| startup_i | input | 1 | Forces all payloads to zero for receiver training |
| ser_o | output | 1 | Serial event lane, idle high |

## Verification
The bench builds the block with 8 inputs, 6-bit identifiers and 2 clock cycles per bit. With these values every one of the 255 non-empty sets of simultaneous requests can be swept. Each sweep step checks the order of frames, their spacing and their payloads against a model that sorts by index. Short bit periods keep the back-to-back frame boundary, the start-bit timing and the merge window inside a few cycles. Directed cases then cover reprogramming, startup mode, held requests and re-firing after launch.

// File: rtl/spike_ser_pkg.sv
package spike_ser_pkg;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    localparam int FRAME_OVERHEAD = 2;

endpackage

// File: rtl/spike_edge_latch.sv
module spike_edge_latch #(
    parameter int N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [N_SRC-1:0] rise;

    always_comb begin
        st_d      = st_q;
        rise      = req_i & ~st_q.prev;
        st_d.prev = req_i;
        // a fresh edge in the clearing cycle is a new event and stays pending
        st_d.pend = (st_q.pend & ~clr_i) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/spike_prio_enc.sv
module spike_prio_enc #(
    parameter int N_SRC = 64,
    parameter int IDX_W = 6
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N_SRC-1:0] onehot_o
);

    logic [N_SRC-1:0] above;

    // above[i] is set when some lower index is pending
    assign above[0] = 1'b0;
    for (genvar g = 1; g < N_SRC; g++) begin : g_chain
        assign above[g] = above[g-1] | pend_i[g-1];
    end

    assign onehot_o = pend_i & ~above;
    assign valid_o  = |pend_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (onehot_o[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/spike_id_table.sv
module spike_id_table #(
    parameter int N_SRC = 64,
    parameter int IDX_W = 6,
    parameter int ID_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [ID_W-1:0]  wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [ID_W-1:0]  rdata_o
);

    logic [ID_W-1:0] tbl_d [N_SRC];
    logic [ID_W-1:0] tbl_q [N_SRC];

    always_comb begin
        for (int i = 0; i < N_SRC; i++) tbl_d[i] = tbl_q[i];
        if (we_i && (int'(waddr_i) < N_SRC)) tbl_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SRC; i++) tbl_q[i] <= ID_W'(i);
        end else begin
            for (int i = 0; i < N_SRC; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    assign rdata_o = (int'(raddr_i) < N_SRC) ? tbl_q[raddr_i] : '0;

endmodule

// File: rtl/spike_frame_tx.sv
module spike_frame_tx
    import spike_ser_pkg::*;
#(
    parameter int ID_W    = 6,
    parameter int BIT_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            startup_i,
    output logic            take_o,
    output logic            ser_o
);

    localparam int FRAME_BITS = ID_W + FRAME_OVERHEAD;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);
    localparam int CYC_W      = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);
    localparam logic [CYC_W-1:0]     LAST_CYC = CYC_W'(BIT_CYC - 1);

    typedef struct packed {
        tx_state_e             st;
        logic [FRAME_BITS-1:0] sh;
        logic [BIT_IDX_W-1:0]  bit_n;
        logic [CYC_W-1:0]      cyc;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   last_cyc;
    logic   frame_end;
    logic   take;

    always_comb begin
        st_d      = st_q;
        last_cyc  = (st_q.cyc == LAST_CYC);
        frame_end = (st_q.st == TX_SEND) && last_cyc && (st_q.bit_n == LAST_BIT);
        take      = valid_i && ((st_q.st == TX_IDLE) || frame_end);

        if (take) begin
            st_d.st    = TX_SEND;
            st_d.sh    = {1'b0, (startup_i ? {ID_W{1'b0}} : id_i), 1'b1};
            st_d.bit_n = '0;
            st_d.cyc   = '0;
        end else if (st_q.st == TX_SEND) begin
            if (last_cyc) begin
                st_d.cyc = '0;
                if (st_q.bit_n == LAST_BIT) begin
                    st_d.st = TX_IDLE;
                end else begin
                    st_d.bit_n = st_q.bit_n + 1'b1;
                    st_d.sh    = {st_q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end else begin
                st_d.cyc = st_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st    <= TX_IDLE;
            st_q.sh    <= '1;
            st_q.bit_n <= '0;
            st_q.cyc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o = take;
    assign ser_o  = (st_q.st == TX_SEND) ? st_q.sh[FRAME_BITS-1] : 1'b1;

endmodule

// File: rtl/spike_serializer.sv
module spike_serializer #(
    parameter int N_SRC   = 64,
    parameter int ID_W    = 6,
    parameter int BIT_CYC = 2,
    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_addr_i,
    input  logic [ID_W-1:0]  cfg_id_i,
    input  logic             startup_i,
    output logic             ser_o
);

    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] onehot_w;
    logic [N_SRC-1:0] grant_w;
    logic             win_valid_w;
    logic [IDX_W-1:0] win_idx_w;
    logic [ID_W-1:0]  win_id_w;
    logic             take_w;

    spike_edge_latch #(.N_SRC(N_SRC)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .clr_i  (grant_w),
        .pend_o (pend_w)
    );

    spike_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) prio_i (
        .pend_i   (pend_w),
        .valid_o  (win_valid_w),
        .idx_o    (win_idx_w),
        .onehot_o (onehot_w)
    );

    spike_id_table #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ID_W(ID_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .waddr_i (cfg_addr_i),
        .wdata_i (cfg_id_i),
        .raddr_i (win_idx_w),
        .rdata_o (win_id_w)
    );

    spike_frame_tx #(.ID_W(ID_W), .BIT_CYC(BIT_CYC)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (win_valid_w),
        .id_i      (win_id_w),
        .startup_i (startup_i),
        .take_o    (take_w),
        .ser_o     (ser_o)
    );

    assign grant_w = take_w ? onehot_w : '0;

endmodule

// File: rtl/spike_serializer_chk.sv
module spike_serializer_chk #(
    parameter int N_SRC   = 64,
    parameter int ID_W    = 6,
    parameter int BIT_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_o,
    input logic             startup_i,
    input logic [N_SRC-1:0] grant,
    input logic [N_SRC-1:0] pend
);

    localparam int FRAME_CYC = (ID_W + 2) * BIT_CYC;
    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    int   fcnt_q;
    logic seen_q;
    logic su_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= 0;
            seen_q <= 1'b0;
            su_q   <= 1'b0;
        end else if (grant != '0) begin
            fcnt_q <= 0;
            seen_q <= 1'b1;
            su_q   <= startup_i;
        end else if (fcnt_q < FRAME_CYC) begin
            fcnt_q <= fcnt_q + 1;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q || fcnt_q >= FRAME_CYC) |-> ser_o); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && fcnt_q < BIT_CYC) |-> !ser_o); // R3

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && fcnt_q >= FRAME_CYC - BIT_CYC && fcnt_q < FRAME_CYC) |-> ser_o); // R3

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((pend & (grant - ONE)) == '0) && ((grant & pend) == grant))); // R5

    AST_LAUNCH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (!seen_q || fcnt_q >= FRAME_CYC - 1)); // R6

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && fcnt_q == FRAME_CYC - 1 && pend != '0) |-> (grant != '0)); // R6

    AST_STARTUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && su_q && fcnt_q >= BIT_CYC && fcnt_q < FRAME_CYC - BIT_CYC) |-> !ser_o); // R7

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~grant) != '0) |=>
        ((pend & $past(pend & ~grant)) == $past(pend & ~grant))); // R8

endmodule

bind spike_serializer spike_serializer_chk #(
    .N_SRC   (N_SRC),
    .ID_W    (ID_W),
    .BIT_CYC (BIT_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_o     (ser_o),
    .startup_i (startup_i),
    .grant     (grant_w),
    .pend      (pend_w)
);

// File: tb/spike_serializer_tb.sv
module spike_serializer_tb_top;

    localparam int N    = 8;
    localparam int IW   = 6;
    localparam int BC   = 2;
    localparam int AW   = 3;
    localparam int FCYC = (IW + 2) * BC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [IW-1:0] cfg_id = '0;
    logic          startup = 1'b0;
    logic          ser;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [IW-1:0] tb_id [N];

    // receiver state (written only by the receiver process)
    int            rx_n    = 0;
    int            rx_ferr = 0;
    int            rx_cnt  = 0;
    bit            rx_busy = 0;
    logic [IW-1:0] rx_sh   = '0;
    logic [IW-1:0] rx_id    [64];
    int            rx_start [64];

    int base;
    int ferr_base;
    int c0;

    spike_serializer #(.N_SRC(N), .ID_W(IW), .BIT_CYC(BC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .cfg_we_i   (cfg_we),
        .cfg_addr_i (cfg_addr),
        .cfg_id_i   (cfg_id),
        .startup_i  (startup),
        .ser_o      (ser)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            rx_busy = 0;
            rx_cnt  = 0;
        end else if (!rx_busy) begin
            if (ser == 1'b0) begin
                rx_busy = 1;
                rx_cnt  = 0;
                rx_start[rx_n % 64] = cyc;
            end
        end else begin
            rx_cnt = rx_cnt + 1;
            if ((rx_cnt % BC == 0) && rx_cnt >= BC && rx_cnt <= IW * BC)
                rx_sh = {rx_sh[IW-2:0], ser};
            if (rx_cnt == (IW + 1) * BC && ser != 1'b1)
                rx_ferr = rx_ferr + 1;
            if (rx_cnt == FCYC - 1) begin
                rx_id[rx_n % 64] = rx_sh;
                rx_n    = rx_n + 1;
                rx_busy = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic program_id(input int idx, input int val);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = AW'(idx);
        cfg_id   = IW'(val);
        @(negedge clk);
        cfg_we   = 1'b0;
        tb_id[idx] = IW'(val);
    endtask

    task automatic fire(input int mask, input int hold);
        @(negedge clk);
        base      = rx_n;
        ferr_base = rx_ferr;
        c0        = cyc;
        req       = N'(mask);
        repeat (hold) @(negedge clk);
        req       = '0;
    endtask

    task automatic wait_frames(input int n);
        repeat (n * FCYC + 8) @(negedge clk);
    endtask

    task automatic verify(input int mask, input bit su);
        int exp_n;
        int k;
        exp_n = $countones(N'(mask));
        k = 0;
        chk(rx_n - base == exp_n, "R5 frame count", rx_n - base, exp_n);
        for (int i = 0; i < N; i++) begin
            if (mask[i] && k < rx_n - base) begin
                int exp_v;
                exp_v = su ? 0 : int'(tb_id[i]);
                if (su) chk(int'(rx_id[(base + k) % 64]) == exp_v, "R7 payload", int'(rx_id[(base + k) % 64]), exp_v);
                else    chk(int'(rx_id[(base + k) % 64]) == exp_v, "R5 order/R4 payload", int'(rx_id[(base + k) % 64]), exp_v);
                if (k == 0) chk(rx_start[base % 64] == c0 + 2, "R2 start timing", rx_start[base % 64], c0 + 2);
                else chk(rx_start[(base + k) % 64] - rx_start[(base + k - 1) % 64] == FCYC,
                         "R6 spacing", rx_start[(base + k) % 64] - rx_start[(base + k - 1) % 64], FCYC);
                k++;
            end
        end
        chk(rx_ferr == ferr_base, "R3 stop bit", rx_ferr, ferr_base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) tb_id[i] = IW'(i);
        repeat (4) @(negedge clk);
        chk(ser == 1'b1, "R1 idle in reset", int'(ser), 1);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(ser == 1'b1, "R1 idle after reset", int'(ser), 1);
        end

        // default table contents
        fire(32'h08, 1);
        wait_frames(1);
        verify(32'h08, 1'b0);

        for (int i = 0; i < N; i++) program_id(i, (i * 37 + 5) % 64);

        // single inputs
        for (int i = 0; i < N; i++) begin
            fire(1 << i, 1);
            wait_frames(1);
            verify(1 << i, 1'b0);
        end

        // every set of simultaneous requests
        for (int m = 1; m < (1 << N); m++) begin
            fire(m, 1);
            wait_frames($countones(N'(m)));
            verify(m, 1'b0);
        end

        // R8: second edge while still pending merges
        fire(32'h21, 1);
        repeat (3) @(negedge clk);
        req = 8'h20;
        @(negedge clk);
        req = '0;
        wait_frames(2);
        chk(rx_n - base == 2, "R8 merged count", rx_n - base, 2);
        verify(32'h21, 1'b0);

        // R9: new edge after launch gives another frame
        fire(32'h08, 1);
        repeat (4) @(negedge clk);
        req = 8'h08;
        @(negedge clk);
        req = '0;
        wait_frames(2);
        chk(rx_n - base == 2, "R9 refire count", rx_n - base, 2);
        chk(int'(rx_id[(base + 1) % 64]) == int'(tb_id[3]), "R9 refire payload",
            int'(rx_id[(base + 1) % 64]), int'(tb_id[3]));
        chk(rx_start[(base + 1) % 64] - rx_start[base % 64] == FCYC, "R6 refire spacing",
            rx_start[(base + 1) % 64] - rx_start[base % 64], FCYC);

        // R10: held level sends once
        fire(32'h04, 60);
        wait_frames(1);
        chk(rx_n - base == 1, "R10 held level", rx_n - base, 1);

        // R7: startup mode
        startup = 1'b1;
        fire(32'hFF, 1);
        wait_frames(N);
        verify(32'hFF, 1'b1);
        startup = 1'b0;

        // R4: reprogramming an entry
        program_id(4, 42);
        fire(32'h10, 1);
        wait_frames(1);
        verify(32'h10, 1'b0);
        chk(int'(rx_id[base % 64]) == 42, "R4 rewritten id", int'(rx_id[base % 64]), 42);

        @(negedge clk);
        chk(ser == 1'b1, "R1 idle at end", int'(ser), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule